// File: doc/BRIEF.md
# Indirectly Addressed Interrupt Status Register File

This block is a small host-visible register file reached through two ports. The host first loads a register index into the pointer port. Reads and writes on the data port then go to whichever register that index selects. Three registers are mapped:

- **Index 0, status/control register.** It holds four event flags raised by the datapath, a read-only error summary bit, a global interrupt enable and a stop command bit.
- **Index 3, mask register.** It holds one mask bit per interrupt-capable flag.
- **Index 112, missed-frame counter.** It counts missed-frame events.

The flags are cleared by writing ones to them. A host can read the status register and write the same value back, and that clears exactly the flags it saw. The interrupt output is a level signal. It stays high while any enabled, unmasked flag is set. The collision-error flag is one exception: it feeds the error summary but never raises the interrupt.

Two reset inputs exist. A hardware reset (`rst`) and a software reset (`sw_rst`) both bring everything back to zero. A stop command only clears the four flags and keeps the pointer, the enable, the masks and the counter.

Top module: `irq_status_regfile`

## Requirements
- R1: Writing `ptr_wdata` with `ptr_wr_en` sets the pointer, and `ptr_rdata` returns it. The data port reads and writes the register the pointer selects: 0 = status, 3 = mask, 112 = missed counter. Any other index reads as zero and ignores writes.
- R2: The pointer clears to 0 on `rst` or `sw_rst`. A stop command does not change it.
- R3: An event pulse sets its flag in the status register on the next clock: babble = bit 14, collision error = bit 13, missed frame = bit 12, memory error = bit 11. Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R4: If an event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: Status bit 15 reads as the OR of flags 14..11. It is read-only, and writing it has no effect.
- R6: `irq` is high exactly when the enable (status bit 6) is 1 and at least one of babble, missed or memory error is set with its mask bit clear. The mask bits are mask register bits 14, 12 and 11. Collision error never raises `irq`.
- R7: Writing 1 to status bit 2 (stop) clears all four flags on the next clock. This holds even against an event in the same cycle. The enable, the masks and the counter are kept.
- R8: `rst` and `sw_rst` each clear the flags, the enable, the masks, the counter and the pointer. After either reset, `irq` is low and every register reads 0.
- R9: Each missed-frame event increments the missed counter by 1, modulo 2^CNT_W. The counter ignores host writes.
- R10: Bits 31..16 of every read are zero. Unused bit positions in the status and mask registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| sw_rst | input | 1 | Synchronous software reset, active high |
| ptr_wr_en | input | 1 | Load the register pointer |
| ptr_wdata | input | PTR_W | New pointer value |
| ptr_rdata | output | PTR_W | Current pointer value |
| data_wr_en | input | 1 | Write the selected register |
| data_wdata | input | 32 | Data port write value |
| data_rdata | output | 32 | Selected register contents (combinational) |
| ev_babble | input | 1 | Babble event pulse |
| ev_coll_err | input | 1 | Collision-error event pulse |
| ev_missed | input | 1 | Missed-frame event pulse |
| ev_mem_err | input | 1 | Memory-error event pulse |
| irq | output | 1 | Level interrupt request |

## Verification
A wrongly held flag shows on the very next status read and, when the flag is interrupt-capable and unmasked, on `irq` in the same cycle. Both outputs are driven directly from registers through combinational logic, so an error is visible one clock after the offending event or write. A wrong mask or enable decode shows up only for certain combinations of flag, mask and enable. For that reason the bench sweeps every flag pattern against every mask pattern and both enable values. A counter that drifts shows on the next read of index 112. Wrap-around is exercised with a narrow counter.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_SRC  = 4;
    localparam int FLAG_LSB = 11;
    localparam int ERR_BIT  = 15;
    localparam int IEN_BIT  = 6;
    localparam int STOP_BIT = 2;

    localparam int IDX_STATUS  = 0;
    localparam int IDX_MASK    = 3;
    localparam int IDX_MISSCNT = 112;

    // flag vector order: index = bit position - FLAG_LSB
    typedef enum int {
        SRC_MEMERR = 0,
        SRC_MISSED = 1,
        SRC_COLL   = 2,
        SRC_BABBLE = 3
    } src_e;

    // collision error feeds the summary but never the interrupt
    localparam logic [NUM_SRC-1:0] IRQ_CAPABLE = 4'b1011;

    typedef struct packed {
        logic status;
        logic mask;
        logic misscnt;
    } reg_sel_t;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic [NUM_SRC-1:0] flags,
        input logic               ien
    );
        logic [DATA_W-1:0] w;
        w = '0;
        w[ERR_BIT]                  = |flags;
        w[FLAG_LSB +: NUM_SRC]      = flags;
        w[IEN_BIT]                  = ien;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_mask(input logic [NUM_SRC-1:0] m);
        logic [DATA_W-1:0] w;
        w = '0;
        w[FLAG_LSB +: NUM_SRC] = m;
        return w;
    endfunction

endpackage

// File: rtl/isr_ptr_reg.sv
module isr_ptr_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (clr)        q <= '0;
        else if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/isr_flag_bank.sv
module isr_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         stop,
    input  logic         w1c_en,
    input  logic [N-1:0] w1c_bits,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (clr || stop)                   flags[i] <= 1'b0;
            else if (set[i])                   flags[i] <= 1'b1;
            else if (w1c_en && w1c_bits[i])    flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/isr_event_counter.sv
module isr_event_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (clr)      count <= '0;
        else if (inc) count <= count + W'(1);
    end
endmodule

// File: rtl/irq_status_regfile.sv
module irq_status_regfile
    import irq_status_pkg::*;
#(
    parameter int PTR_W = 7,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_rst,
    input  logic              ptr_wr_en,
    input  logic [PTR_W-1:0]  ptr_wdata,
    output logic [PTR_W-1:0]  ptr_rdata,
    input  logic              data_wr_en,
    input  logic [DATA_W-1:0] data_wdata,
    output logic [DATA_W-1:0] data_rdata,
    input  logic              ev_babble,
    input  logic              ev_coll_err,
    input  logic              ev_missed,
    input  logic              ev_mem_err,
    output logic              irq
);
    localparam logic [PTR_W-1:0] SEL_STATUS  = PTR_W'(IDX_STATUS);
    localparam logic [PTR_W-1:0] SEL_MASK    = PTR_W'(IDX_MASK);
    localparam logic [PTR_W-1:0] SEL_MISSCNT = PTR_W'(IDX_MISSCNT);

    logic               clr_all;
    logic [PTR_W-1:0]   ptr_q;
    reg_sel_t           sel;
    logic               wr_status;
    logic               stop_cmd;
    logic [NUM_SRC-1:0] ev_vec;
    logic [NUM_SRC-1:0] flags_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               ien_q;
    logic [CNT_W-1:0]   cnt_q;

    assign clr_all = rst | sw_rst;

    isr_ptr_reg #(.W(PTR_W)) u_ptr (
        .clk   (clk),
        .clr   (clr_all),
        .wr_en (ptr_wr_en),
        .wdata (ptr_wdata),
        .q     (ptr_q)
    );

    assign ptr_rdata   = ptr_q;
    assign sel.status  = (ptr_q == SEL_STATUS);
    assign sel.mask    = (ptr_q == SEL_MASK);
    assign sel.misscnt = (ptr_q == SEL_MISSCNT);

    assign wr_status = data_wr_en & sel.status;
    assign stop_cmd  = wr_status & data_wdata[STOP_BIT];

    always_comb begin
        ev_vec             = '0;
        ev_vec[SRC_BABBLE] = ev_babble;
        ev_vec[SRC_COLL]   = ev_coll_err;
        ev_vec[SRC_MISSED] = ev_missed;
        ev_vec[SRC_MEMERR] = ev_mem_err;
    end

    isr_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk      (clk),
        .clr      (clr_all),
        .stop     (stop_cmd),
        .w1c_en   (wr_status),
        .w1c_bits (data_wdata[FLAG_LSB +: NUM_SRC]),
        .set      (ev_vec),
        .flags    (flags_q)
    );

    always_ff @(posedge clk) begin
        if (clr_all) begin
            ien_q  <= 1'b0;
            mask_q <= '0;
        end else begin
            if (wr_status)
                ien_q <= data_wdata[IEN_BIT];
            if (data_wr_en && sel.mask)
                mask_q <= data_wdata[FLAG_LSB +: NUM_SRC] & IRQ_CAPABLE;
        end
    end

    isr_event_counter #(.W(CNT_W)) u_miss_cnt (
        .clk   (clk),
        .clr   (clr_all),
        .inc   (ev_missed),
        .count (cnt_q)
    );

    always_comb begin
        data_rdata = '0;
        if (sel.status)       data_rdata = pack_status(flags_q, ien_q);
        else if (sel.mask)    data_rdata = pack_mask(mask_q);
        else if (sel.misscnt) data_rdata = DATA_W'(cnt_q);
    end

    assign irq = ien_q & (|(flags_q & IRQ_CAPABLE & ~mask_q));

endmodule

// File: rtl/irq_status_regfile_chk.sv
module irq_status_regfile_chk
    import irq_status_pkg::*;
#(
    parameter int PTR_W = 7,
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               sw_rst,
    input logic               ptr_wr_en,
    input logic               data_wr_en,
    input logic [DATA_W-1:0]  data_wdata,
    input logic [DATA_W-1:0]  data_rdata,
    input logic [PTR_W-1:0]   ptr_q,
    input logic [NUM_SRC-1:0] flags_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               ien_q,
    input logic [CNT_W-1:0]   cnt_q,
    input logic               ev_babble,
    input logic               ev_missed,
    input logic               irq
);
    logic at_status;
    logic stop_wr;
    assign at_status = (ptr_q == PTR_W'(IDX_STATUS));
    assign stop_wr   = data_wr_en && at_status && data_wdata[STOP_BIT];

    // R2: a stop command leaves the pointer alone
    p_ptr_keep_on_stop_r2: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (stop_wr && !ptr_wr_en) |=> $stable(ptr_q));

    // R7: stop clears every flag, even against a simultaneous event
    p_stop_clears_r7: assert property (@(posedge clk) disable iff (rst || sw_rst)
        stop_wr |=> (flags_q == '0));

    // R4: an event is never lost to a same-cycle clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (ev_babble && !stop_wr) |=> flags_q[SRC_BABBLE]);

    // R5: the summary bit on the data port tracks the flag bank
    p_err_summary_r5: assert property (@(posedge clk) disable iff (rst || sw_rst)
        at_status |-> (data_rdata[ERR_BIT] == (|flags_q)));

    // R6: interrupt only from an enabled, unmasked, interrupt-capable flag
    p_irq_source_r6: assert property (@(posedge clk) disable iff (rst || sw_rst)
        irq |-> (ien_q && ((flags_q & IRQ_CAPABLE & ~mask_q) != '0)));

    // R9: each missed event advances the counter by one
    p_miss_count_r9: assert property (@(posedge clk) disable iff (rst || sw_rst)
        ev_missed |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R10: reserved upper half reads as zero
    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (rst || sw_rst)
        data_rdata[31:16] == 16'h0);

endmodule

bind irq_status_regfile irq_status_regfile_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_rst     (sw_rst),
    .ptr_wr_en  (ptr_wr_en),
    .data_wr_en (data_wr_en),
    .data_wdata (data_wdata),
    .data_rdata (data_rdata),
    .ptr_q      (ptr_q),
    .flags_q    (flags_q),
    .mask_q     (mask_q),
    .ien_q      (ien_q),
    .cnt_q      (cnt_q),
    .ev_babble  (ev_babble),
    .ev_missed  (ev_missed),
    .irq        (irq)
);

// File: tb/tb_irq_status_regfile.sv
module tb_irq_status_regfile;
    localparam int PTR_W = 7;
    localparam int CNT_W = 4;

    logic              clk = 1'b0;
    logic              rst, sw_rst;
    logic              ptr_wr_en;
    logic [PTR_W-1:0]  ptr_wdata;
    logic [PTR_W-1:0]  ptr_rdata;
    logic              data_wr_en;
    logic [31:0]       data_wdata;
    logic [31:0]       data_rdata;
    logic              ev_babble, ev_coll_err, ev_missed, ev_mem_err;
    logic              irq;

    int checks   = 0;
    int failures = 0;
    int miss_total = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_status_regfile #(.PTR_W(PTR_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .sw_rst(sw_rst),
        .ptr_wr_en(ptr_wr_en), .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata),
        .data_wr_en(data_wr_en), .data_wdata(data_wdata), .data_rdata(data_rdata),
        .ev_babble(ev_babble), .ev_coll_err(ev_coll_err),
        .ev_missed(ev_missed), .ev_mem_err(ev_mem_err), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic set_ptr(input int idx);
        ptr_wr_en = 1'b1; ptr_wdata = PTR_W'(idx);
        cyc();
        ptr_wr_en = 1'b0;
    endtask

    task automatic wr_data(input logic [31:0] d);
        data_wr_en = 1'b1; data_wdata = d;
        cyc();
        data_wr_en = 1'b0; data_wdata = '0;
    endtask

    // f: [3]=babble [2]=collision [1]=missed [0]=memory error
    task automatic fire(input logic [3:0] f);
        ev_mem_err = f[0]; ev_missed = f[1]; ev_coll_err = f[2]; ev_babble = f[3];
        cyc();
        ev_mem_err = 0; ev_missed = 0; ev_coll_err = 0; ev_babble = 0;
        if (f[1]) miss_total++;
    endtask

    function automatic logic [31:0] st(input logic [3:0] f, input logic en);
        return {16'h0, |f, f, 4'h0, en, 6'h0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1; sw_rst = 0; ptr_wr_en = 0; ptr_wdata = '0;
        data_wr_en = 0; data_wdata = '0;
        ev_babble = 0; ev_coll_err = 0; ev_missed = 0; ev_mem_err = 0;
        repeat (3) cyc();
        rst = 0;
        cyc();

        // R8: reset state
        check("R8 ptr after reset", 32'(ptr_rdata), 32'h0);
        check("R8 status after reset", data_rdata, 32'h0);
        check("R8 irq after reset", 32'(irq), 32'h0);

        // R1: pointer readback and unmapped index
        set_ptr(5);
        check("R1 ptr readback", 32'(ptr_rdata), 32'h5);
        wr_data(32'hFFFF_FFFF);
        check("R1 unmapped reads zero", data_rdata, 32'h0);
        set_ptr(0);
        check("R1 unmapped write ignored", data_rdata, 32'h0);

        // R3/R5/R6/R10: sweep flags x masks x enable
        for (int f = 0; f < 16; f++) begin
            for (int m = 0; m < 8; m++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [3:0] mv;
                    logic       exp_irq;
                    mv = {m[2], 1'b0, m[1], m[0]};
                    exp_irq = (e == 1) && ((4'(f) & 4'b1011 & ~mv) != 4'h0);
                    set_ptr(3);
                    wr_data({16'h0, 1'b0, mv, 11'h0});
                    check("R6 mask readback", data_rdata, {16'h0, 1'b0, mv, 11'h0});
                    set_ptr(0);
                    wr_data({25'h0, 1'(e), 6'h0});
                    fire(4'(f));
                    check("R6 irq level", 32'(irq), 32'(exp_irq));
                    v = data_rdata;
                    check("R3 R5 R10 status read", v, st(4'(f), 1'(e)));
                    wr_data(v);
                    check("R3 write-back clears", data_rdata, st(4'h0, 1'(e)));
                    check("R6 irq after clear", 32'(irq), 32'h0);
                end
            end
        end

        // R9: counter, wrapped modulo 16
        set_ptr(112);
        check("R9 missed counter wrap", data_rdata, 32'(miss_total % 16));
        wr_data(32'h0000_0005);
        check("R9 counter ignores writes", data_rdata, 32'(miss_total % 16));
        set_ptr(0);

        // R3: write 0 no effect, partial clear; R5: bit 15 write ignored
        wr_data(32'h40);
        fire(4'hF);
        wr_data(32'h40);
        check("R3 write zero no effect", data_rdata, st(4'hF, 1));
        wr_data(32'h0000_2040);
        check("R3 single clear", data_rdata, st(4'hB, 1));
        wr_data(32'h0000_8040);
        check("R5 summary write ignored", data_rdata, st(4'hB, 1));
        wr_data(32'h0000_0040 | 32'h0000_5800 & 32'h0000_4000);
        check("R3 clear babble", data_rdata, st(4'h3, 1));
        wr_data(32'h0000_1840);
        check("R5 summary drops", data_rdata, st(4'h0, 1));

        // R4: set beats same-cycle clear
        set_ptr(3); wr_data(32'h0); set_ptr(0);
        ev_babble = 1; data_wr_en = 1; data_wdata = 32'h0000_4040;
        cyc();
        ev_babble = 0; data_wr_en = 0; data_wdata = '0;
        check("R4 set wins", data_rdata, st(4'h8, 1));
        check("R4 irq raised", 32'(irq), 32'h1);

        // R6: collision alone never interrupts
        wr_data(32'h0000_4040);
        fire(4'h4);
        check("R6 collision no irq", 32'(irq), 32'h0);
        check("R6 collision sets summary", data_rdata, st(4'h4, 1));

        // R7: stop clears flags over simultaneous event; enable, mask, counter kept
        set_ptr(3); wr_data(32'h0000_0800); set_ptr(0);
        fire(4'hF);
        ev_missed = 1; data_wr_en = 1; data_wdata = 32'h0000_0044;
        cyc();
        ev_missed = 0; data_wr_en = 0; data_wdata = '0;
        miss_total++;
        check("R7 stop clears flags", data_rdata, st(4'h0, 1));
        check("R2 ptr kept on stop", 32'(ptr_rdata), 32'h0);
        set_ptr(3);
        check("R7 mask kept", data_rdata, 32'h0000_0800);
        set_ptr(112);
        check("R7 counter kept", data_rdata, 32'(miss_total % 16));

        // R8/R2: software reset
        set_ptr(0); fire(4'h8); set_ptr(3);
        sw_rst = 1; cyc(); sw_rst = 0;
        check("R2 ptr cleared by sw reset", 32'(ptr_rdata), 32'h0);
        check("R8 status after sw reset", data_rdata, 32'h0);
        check("R8 irq after sw reset", 32'(irq), 32'h0);
        set_ptr(3);
        check("R8 mask after sw reset", data_rdata, 32'h0);
        set_ptr(112);
        check("R8 counter after sw reset", data_rdata, 32'h0);

        // R2: hardware reset clears pointer
        rst = 1; cyc(); rst = 0;
        check("R2 ptr cleared by hw reset", 32'(ptr_rdata), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule